// File: doc/BRIEF.md
# Variable-Latency Speculative Prefix Adder

This block adds two unsigned operands of `WIDTH` bits and returns the sum together with a carry-out. Its fast path is a prefix carry tree of the Han-Carlson kind whose last Kogge-Stone row has been removed. Each carry is therefore formed from a bounded run of lower bits rather than from the whole operand. Most operand pairs do not need more than that, and for them the result appears one clock after the operands are accepted.

A detection network looks at the propagate and generate bits and raises a flag whenever any truncated carry could differ from the exact carry. When that happens, the speculative result is discarded and the per-bit generate and propagate values are stored. On the next clock a complete, unpruned prefix tree works on those stored values and delivers the exact result. While this correction is pending, `busy` is high and new operands are refused.

The block handles one addition at a time. A caller presents operands with `in_valid` in any cycle where `busy` is low, and collects the result on the single-cycle `out_valid` pulse.

Top module: `spec_prefix_adder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `busy`, `out_sum` and `out_cout` are all zero.
- R2: For every accepted operand pair, `{out_cout, out_sum}` equals the exact value `in_a + in_b` in the cycle in which `out_valid` is high.
- R3: An accepted pair is flagged when, for some bit position i, the propagate bits p[i:lo] are all one and at least one generate bit below lo is one. Here p = a XOR b and g = a AND b. The low end lo is i-WIN+1 for odd i and i-WIN for even i, and positions with lo <= 0 never flag. An accepted pair is not flagged in any other case.
- R4: When an accepted pair is not flagged, `out_valid` is high in the cycle after the accepting clock edge, and `busy` stays low.
- R5: When an accepted pair is flagged, `busy` is high and `out_valid` is low in the cycle after the accepting edge. In the cycle after that, `out_valid` is high and `busy` is low.
- R6: Operands presented with `in_valid` while `busy` is high are ignored. They produce no result pulse and do not change the pending result.
- R7: `out_valid` is a one-cycle pulse for each completed addition. Between pulses, `out_sum` and `out_cout` keep their last values.
- R8: `out_cout` is the exact carry out of the top bit, including on flagged pairs whose carry chain reaches the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present; accepted when `busy` is low |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | One-cycle pulse marking a completed result |
| out_sum | output | WIDTH | Sum bits |
| out_cout | output | 1 | Carry out of the top bit |
| busy | output | 1 | Correction pending; input is refused |

## Verification
Inputs change on the falling edge, and outputs are read on the falling edge that follows each rising edge. An unflagged pair is therefore checked one half-period after its accepting edge. A flagged pair is checked twice: `busy` is read at that same point, and the result one full clock later. The bench derives the expected flag from the window rule in R3 and the expected sum from plain addition, so it knows which cycle each result is due before it samples. After every result, one more cycle is read to confirm that the pulse has ended and the outputs are holding. The ignore case drives new operands during the busy cycle and then confirms that only the pending result appears.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    // Prefix operator: upper group absorbs lower group.
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/spa_hc_tree.sv
// Han-Carlson style prefix tree: one Brent-Kung row on odd bits, KS_ROWS
// Kogge-Stone rows on odd bits (distances 2,4,...), one Brent-Kung row
// folding odd groups into even bits.
module spa_hc_tree
    import spa_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int KS_ROWS = 3
) (
    input  logic [WIDTH-1:0] g_in,
    input  logic [WIDTH-1:0] p_in,
    output logic [WIDTH-1:0] grp_g
);
    localparam int NLEV = KS_ROWS + 2;

    pg_t lvl [NLEV+1][WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_init
        assign lvl[0][i] = '{g: g_in[i], p: p_in[i]};
    end

    for (genvar lv = 0; lv < NLEV; lv++) begin : g_row
        localparam int DIST = (lv == 0 || lv == NLEV-1) ? 1 : (1 << lv);
        for (genvar i = 0; i < WIDTH; i++) begin : g_col
            if (lv == NLEV-1) begin : g_last
                if ((i % 2 == 0) && (i >= 2)) begin : g_blk
                    assign lvl[lv+1][i] = pg_merge(lvl[lv][i], lvl[lv][i-1]);
                end else begin : g_wht
                    assign lvl[lv+1][i] = lvl[lv][i];
                end
            end else begin : g_odd
                if ((i % 2 == 1) && (i >= DIST)) begin : g_blk
                    assign lvl[lv+1][i] = pg_merge(lvl[lv][i], lvl[lv][i-DIST]);
                end else begin : g_wht
                    assign lvl[lv+1][i] = lvl[lv][i];
                end
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_out
        assign grp_g[i] = lvl[NLEV][i].g;
    end

endmodule

// File: rtl/spa_err_net.sv
// Flags operand pairs whose truncated carries may be wrong (R3).
module spa_err_net #(
    parameter int WIDTH = 16,
    parameter int WIN   = 8
) (
    input  logic [WIDTH-1:0] g_in,
    input  logic [WIDTH-1:0] p_in,
    output logic             err
);
    logic [WIDTH-1:0] term;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
        localparam int LO = (i % 2 == 1) ? (i - WIN + 1) : (i - WIN);
        if (LO > 0) begin : g_chk
            assign term[i] = (&p_in[i:LO]) & (|g_in[LO-1:0]);
        end else begin : g_none
            assign term[i] = 1'b0;
        end
    end

    assign err = |term;

endmodule

// File: rtl/spa_post.sv
// Post-processing: sum bits from propagate and incoming carries.
module spa_post #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] p_in,
    input  logic [WIDTH-1:0] carry,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    assign sum  = p_in ^ {carry[WIDTH-2:0], 1'b0};
    assign cout = carry[WIDTH-1];
endmodule

// File: rtl/spec_prefix_adder.sv
module spec_prefix_adder #(
    parameter int WIDTH = 16,
    parameter int WIN   = WIDTH / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout,
    output logic             busy
);
    localparam int FULL_KS = $clog2(WIDTH) - 1;
    localparam int SPEC_KS = $clog2(WIN) - 1;

    typedef struct packed {
        logic             busy;
        logic             vld;
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic [WIDTH-1:0] g_hold;
        logic [WIDTH-1:0] p_hold;
    } st_t;

    st_t st_d, st_q;

    // Pre-processing on the live operands.
    logic [WIDTH-1:0] g_in, p_in;
    assign g_in = in_a & in_b;
    assign p_in = in_a ^ in_b;

    // Speculative path.
    logic [WIDTH-1:0] spec_c, spec_sum;
    logic             spec_cout, spec_err;

    spa_hc_tree #(.WIDTH(WIDTH), .KS_ROWS(SPEC_KS)) u_spec_tree (
        .g_in(g_in), .p_in(p_in), .grp_g(spec_c));
    spa_post #(.WIDTH(WIDTH)) u_spec_post (
        .p_in(p_in), .carry(spec_c), .sum(spec_sum), .cout(spec_cout));
    spa_err_net #(.WIDTH(WIDTH), .WIN(WIN)) u_err (
        .g_in(g_in), .p_in(p_in), .err(spec_err));

    // Correction path on the held generate/propagate values.
    logic [WIDTH-1:0] fix_c, fix_sum;
    logic             fix_cout;

    spa_hc_tree #(.WIDTH(WIDTH), .KS_ROWS(FULL_KS)) u_fix_tree (
        .g_in(st_q.g_hold), .p_in(st_q.p_hold), .grp_g(fix_c));
    spa_post #(.WIDTH(WIDTH)) u_fix_post (
        .p_in(st_q.p_hold), .carry(fix_c), .sum(fix_sum), .cout(fix_cout));

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.busy = 1'b0;
        if (st_q.busy) begin
            st_d.vld  = 1'b1;
            st_d.sum  = fix_sum;
            st_d.cout = fix_cout;
        end else if (in_valid) begin
            if (spec_err) begin
                st_d.busy   = 1'b1;
                st_d.g_hold = g_in;
                st_d.p_hold = p_in;
            end else begin
                st_d.vld  = 1'b1;
                st_d.sum  = spec_sum;
                st_d.cout = spec_cout;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sum   = st_q.sum;
    assign out_cout  = st_q.cout;
    assign busy      = st_q.busy;

    // R2/R3: an unflagged pair must already be exact on the fast path.
    a_r3_spec_exact: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && !spec_err) |->
            ({spec_cout, spec_sum} == ({1'b0, in_a} + {1'b0, in_b})));

    // R5: a pending correction always completes on the next edge.
    a_r5_fix_next: assert property (@(posedge clk) disable iff (rst)
        busy |=> (out_valid && !busy));

    // R5/R8: corrected result equals the held operands' true sum.
    a_r8_fix_value: assert property (@(posedge clk) disable iff (rst)
        busy |=> ({out_cout, out_sum} ==
                  $past({1'b0, st_q.p_hold} + {st_q.g_hold, 1'b0})));

    // R6: busy is only ever entered from an accepted request.
    a_r6_busy_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    // R7: result pulse never coincides with a pending correction.
    a_r7_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && busy));

endmodule

// File: tb/spec_prefix_adder_tb.sv
module spec_prefix_adder_tb;
    localparam int N      = 16;
    localparam int K      = 8;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [N-1:0] in_a, in_b;
    logic         out_valid, out_cout, busy;
    logic [N-1:0] out_sum;

    int errs   = 0;
    int checks = 0;
    int nflag  = 0;
    bit done   = 1'b0;

    spec_prefix_adder #(.WIDTH(N), .WIN(K)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout),
        .busy(busy));

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Window rule of R3, computed from the requirement text.
    function automatic bit exp_flag(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N-1:0] p, g;
        p = a ^ b;
        g = a & b;
        for (int i = 0; i < N; i++) begin
            int lo;
            bit allp, anyg;
            lo   = (i % 2 == 1) ? i - K + 1 : i - K;
            allp = 1'b1;
            anyg = 1'b0;
            if (lo > 0) begin
                for (int j = lo; j <= i; j++) allp &= p[j];
                for (int j = 0; j < lo; j++) anyg |= g[j];
                if (allp && anyg) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic add_op(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] exp;
        bit         fl;
        exp = {1'b0, a} + {1'b0, b};
        fl  = exp_flag(a, b);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (!fl) begin
            chk(out_valid == 1'b1, "R4 fast valid", out_valid, 1);
            chk(busy == 1'b0, "R4 fast busy", busy, 0);
        end else begin
            nflag++;
            chk(busy == 1'b1 && out_valid == 1'b0, "R5 busy cycle",
                {busy, out_valid}, 2);
            @(posedge clk);
            @(negedge clk);
            chk(out_valid == 1'b1 && busy == 1'b0, "R5 late valid",
                {busy, out_valid}, 1);
            chk(out_cout == exp[N], "R8 cout", out_cout, exp[N]);
        end
        chk({out_cout, out_sum} == exp, "R2 sum", {out_cout, out_sum}, exp);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 pulse", out_valid, 0);
        chk({out_cout, out_sum} == exp, "R7 hold", {out_cout, out_sum}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({out_valid, busy, out_cout, out_sum} == 0, "R1 in reset",
            {out_valid, busy, out_cout, out_sum}, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({out_valid, busy, out_cout, out_sum} == 0, "R1 after reset",
            {out_valid, busy, out_cout, out_sum}, 0);

        // R3 directed: flag and no-flag corners.
        chk(exp_flag(16'h7FFF, 16'h0001) == 1'b1, "R3 model flag", 0, 1);
        add_op(16'h7FFF, 16'h0001);   // long chain from bit 0: flagged
        add_op(16'hFFFF, 16'h0001);   // R8 carry to the top, flagged
        add_op(16'hFFFF, 16'h0000);   // all propagate, no generate: fast
        add_op(16'h00FF, 16'h0001);   // chain stops inside window: fast
        add_op(16'hFF00, 16'h0100);   // generate at bit 8 only
        add_op(16'h0000, 16'h0000);
        add_op(16'hFFFF, 16'hFFFF);
        add_op(16'h8000, 16'h8000);   // R8 cout from top generate

        // R6: operands during the busy cycle are ignored.
        @(negedge clk);
        in_valid = 1'b1; in_a = 16'h7FFF; in_b = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy", busy, 1);
        in_a = 16'h1111; in_b = 16'h2222;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({out_cout, out_sum} == 17'h08000, "R6 pending kept",
            {out_cout, out_sum}, 17'h08000);
        chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R6 no extra result",
            {out_valid, busy}, 0);
        chk({out_cout, out_sum} == 17'h08000, "R6 hold",
            {out_cout, out_sum}, 17'h08000);

        // Random mix, with long-propagate shaping to raise the flag rate.
        for (int n = 0; n < 400; n++) begin
            logic [N-1:0] a, b;
            a = N'($urandom);
            b = N'($urandom);
            if (n % 3 == 0) b = ~a ^ N'(1 << ($urandom % 4)) ^ N'($urandom % 4);
            add_op(a, b);
        end
        chk(nflag > 5, "R3 flagged cases seen", nflag, 6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule